// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two bidirectional buses, A and B. It is built as independent lanes of configurable width, two lanes of eight bits by default. Each lane has a direction control and an active-low output enable. Together these decide which bus, if either, the lane drives. Tri-state pins are modelled as separate input, output and output-enable vectors for each bus, so the pad ring can build the real bidirectional pins.

Each lane has two capture registers. One stores the A bus on a rising edge of its A-side strobe, and the other stores the B bus on a rising edge of its B-side strobe. Strobes are sampled on the block clock. For each direction, a source select chooses what the driven bus receives: the live value from the opposite bus, or the register that holds data from that opposite bus. Capture keeps working while the lane is isolated or driving the other way. Data can therefore be parked and replayed later.

Top module: `xcvr_reg_bus`

## Requirements
- R1: In a lane with `en_ni` low, `dir_i` high sets every bit of that lane's `b_oe_o` to 1 and every bit of `a_oe_o` to 0. With `dir_i` low the roles swap.
- R2: In a lane with `en_ni` high, all bits of that lane's `a_oe_o` and `b_oe_o` are 0.
- R3: In no lane are `a_oe_o` and `b_oe_o` both high at the same time.
- R4: A clock edge at which `cap_ab_i` of a lane is 1, after being 0 at the previous edge, loads that lane's A-side register from `a_i`.
- R5: A clock edge at which `cap_ba_i` of a lane is 1, after being 0 at the previous edge, loads that lane's B-side register from `b_i`.
- R6: Capture takes place whatever the values of `en_ni` and `dir_i`, including while the lane is isolated.
- R7: `b_o` of a lane equals that lane's `a_i` when `sel_ab_i` is 0, and equals the A-side register when `sel_ab_i` is 1.
- R8: `a_o` of a lane equals that lane's `b_i` when `sel_ba_i` is 0, and equals the B-side register when `sel_ba_i` is 1.
- R9: Lanes are independent. Lane h uses bits [h*8+7:h*8] of the data vectors and bit h of each control.
- R10: An active-low asynchronous `rst_ni` clears every register to 0.
- R11: A strobe held at 1 across several edges, or across the release of reset, causes no further capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, strobes sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 2 | Per-lane output enable, active low |
| dir_i | input | 2 | Per-lane direction: 1 drives B, 0 drives A |
| cap_ab_i | input | 2 | Per-lane A-side capture strobe |
| cap_ba_i | input | 2 | Per-lane B-side capture strobe |
| sel_ab_i | input | 2 | Per-lane B output source: 0 live A, 1 stored A |
| sel_ba_i | input | 2 | Per-lane A output source: 0 live B, 1 stored B |
| a_i | input | 16 | A bus input value |
| b_i | input | 16 | B bus input value |
| a_o | output | 16 | Value for the A bus pins |
| a_oe_o | output | 16 | A bus drive enable per bit |
| b_o | output | 16 | Value for the B bus pins |
| b_oe_o | output | 16 | B bus drive enable per bit |

## Verification
The capture properties assume that strobes and data are synchronous to `clk_i` and stable around its rising edge. They also assume that `rst_ni` is held low at time zero. The stimulus keeps within these limits: it changes every input on the falling clock edge and starts in reset. It raises each strobe only after at least one edge at 0, except in the corner that deliberately holds a strobe high across reset release. The bench treats `a_i` and `b_i` as always readable. It therefore also drives them while the lane drives the same bus, which is how capture during drive is exercised.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_dir_ctl.sv
module xcvr_dir_ctl (
  input  logic en_ni,
  input  logic dir_i,
  output logic drv_a_o,
  output logic drv_b_o
);
  assign drv_b_o = ~en_ni & dir_i;
  assign drv_a_o = ~en_ni & ~dir_i;

  always_comb begin
    // R3
    no_dual_drive_chk : assert (!(drv_a_o && drv_b_o))
      else $error("both buses driven");
  end
endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic strobe_q;

  // tracks the strobe level through reset so a held level is not a rise
  always_ff @(posedge clk_i) strobe_q <= strobe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   q_o <= '0;
    else if (strobe_i && !strobe_q) q_o <= d_i;
  end

  // R4 R5 R6
  capture_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_i) |=> (q_o == $past(d_i)));

  // R11
  hold_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(strobe_i) |=> $stable(q_o));
endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] y_o
);
  src_sel_e src;
  assign src = src_sel_e'(sel_i);

  always_comb begin
    unique case (src)
      SRC_STORED: y_o = stored_i;
      default:    y_o = live_i;
    endcase
  end
endmodule

// File: rtl/xcvr_reg_bus.sv
module xcvr_reg_bus #(
  parameter int LANE_W  = 8,
  parameter int N_LANES = 2,
  localparam int BUS_W  = LANE_W * N_LANES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LANES-1:0] en_ni,
  input  logic [N_LANES-1:0] dir_i,
  input  logic [N_LANES-1:0] cap_ab_i,
  input  logic [N_LANES-1:0] cap_ba_i,
  input  logic [N_LANES-1:0] sel_ab_i,
  input  logic [N_LANES-1:0] sel_ba_i,
  input  logic [BUS_W-1:0]   a_i,
  input  logic [BUS_W-1:0]   b_i,
  output logic [BUS_W-1:0]   a_o,
  output logic [BUS_W-1:0]   a_oe_o,
  output logic [BUS_W-1:0]   b_o,
  output logic [BUS_W-1:0]   b_oe_o
);
  for (genvar h = 0; h < N_LANES; h++) begin : g_lane
    logic              drv_a, drv_b;
    logic [LANE_W-1:0] ab_q, ba_q;

    xcvr_dir_ctl u_ctl (
      .en_ni   (en_ni[h]),
      .dir_i   (dir_i[h]),
      .drv_a_o (drv_a),
      .drv_b_o (drv_b)
    );

    xcvr_cap_reg #(.W(LANE_W)) u_ab_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (cap_ab_i[h]),
      .d_i      (a_i[h*LANE_W +: LANE_W]),
      .q_o      (ab_q)
    );

    xcvr_cap_reg #(.W(LANE_W)) u_ba_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (cap_ba_i[h]),
      .d_i      (b_i[h*LANE_W +: LANE_W]),
      .q_o      (ba_q)
    );

    xcvr_src_mux #(.W(LANE_W)) u_b_mux (
      .sel_i    (sel_ab_i[h]),
      .live_i   (a_i[h*LANE_W +: LANE_W]),
      .stored_i (ab_q),
      .y_o      (b_o[h*LANE_W +: LANE_W])
    );

    xcvr_src_mux #(.W(LANE_W)) u_a_mux (
      .sel_i    (sel_ba_i[h]),
      .live_i   (b_i[h*LANE_W +: LANE_W]),
      .stored_i (ba_q),
      .y_o      (a_o[h*LANE_W +: LANE_W])
    );

    assign a_oe_o[h*LANE_W +: LANE_W] = {LANE_W{drv_a}};
    assign b_oe_o[h*LANE_W +: LANE_W] = {LANE_W{drv_b}};

    always_comb begin
      // R2
      if (en_ni[h])
        isolate_chk : assert (a_oe_o[h*LANE_W +: LANE_W] == '0 &&
                              b_oe_o[h*LANE_W +: LANE_W] == '0)
          else $error("isolated lane drives");
      // R7
      if (!sel_ab_i[h])
        live_ab_chk : assert (b_o[h*LANE_W +: LANE_W] == a_i[h*LANE_W +: LANE_W])
          else $error("live A path broken");
      // R8
      if (!sel_ba_i[h])
        live_ba_chk : assert (a_o[h*LANE_W +: LANE_W] == b_i[h*LANE_W +: LANE_W])
          else $error("live B path broken");
    end
  end
endmodule

// File: tb/sim_xcvr_reg_bus.sv
module sim_xcvr_reg_bus;
  localparam int W  = 8;
  localparam int NL = 2;
  localparam int BW = W * NL;
  localparam int NV = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] en_ni = '1, dir_i = '0, cap_ab_i = '0, cap_ba_i = '0;
  logic [NL-1:0] sel_ab_i = '0, sel_ba_i = '0;
  logic [BW-1:0] a_i = '0, b_i = '0;
  logic [BW-1:0] a_o, a_oe_o, b_o, b_oe_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  xcvr_reg_bus u0 (.*);

  // {en_n, dir, cap_ab, cap_ba, sel_ab, sel_ba, a, b}
  localparam logic [43:0] VEC [NV] = '{
    {2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'h1234, 16'habcd},
    {2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 16'h1234, 16'habcd},
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'h1234, 16'habcd},
    {2'b11, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 16'h5a5a, 16'habcd},
    {2'b11, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 16'h0000, 16'habcd},
    {2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'hffff, 16'habcd},
    {2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 16'hffff, 16'hc3c3},
    {2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 16'hffff, 16'h0000},
    {2'b01, 2'b10, 2'b00, 2'b00, 2'b10, 2'b00, 16'h7777, 16'h0000},
    {2'b00, 2'b01, 2'b01, 2'b10, 2'b11, 2'b11, 16'h1111, 16'h2222}
  };

  task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] ab_m, ba_m;
    logic [NL-1:0] pab, pba;
    ab_m = '0; ba_m = '0; pab = '0; pba = '0;

    repeat (3) @(negedge clk_i);
    // R2 R10: reset state, isolated
    check("R2 R10 a_oe", a_oe_o, '0);
    check("R2 R10 b_oe", b_oe_o, '0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [43:0] e;
      logic [BW-1:0] ea, eb, eaoe, eboe;
      e = VEC[v];
      @(negedge clk_i);
      {en_ni, dir_i, cap_ab_i, cap_ba_i, sel_ab_i, sel_ba_i, a_i, b_i} = e;
      @(posedge clk_i);
      for (int h = 0; h < NL; h++) begin
        if (cap_ab_i[h] && !pab[h]) ab_m[h*W +: W] = a_i[h*W +: W];
        if (cap_ba_i[h] && !pba[h]) ba_m[h*W +: W] = b_i[h*W +: W];
        ea[h*W +: W]   = sel_ba_i[h] ? ba_m[h*W +: W] : b_i[h*W +: W];
        eb[h*W +: W]   = sel_ab_i[h] ? ab_m[h*W +: W] : a_i[h*W +: W];
        eaoe[h*W +: W] = {W{!en_ni[h] && !dir_i[h]}};
        eboe[h*W +: W] = {W{!en_ni[h] && dir_i[h]}};
      end
      pab = cap_ab_i;
      pba = cap_ba_i;
      #2;
      // R1 R2 R9
      check("R1 R2 R9 a_oe", a_oe_o, eaoe);
      check("R1 R2 R9 b_oe", b_oe_o, eboe);
      // R4 R6 R7 R11
      check("R4 R6 R7 R11 b_o", b_o, eb);
      // R5 R6 R8 R9
      check("R5 R6 R8 R9 a_o", a_o, ea);
      // R3
      check("R3 dual", a_oe_o & b_oe_o, '0);
    end

    // R10: reset clears stored data, strobe held high through it
    @(negedge clk_i);
    rst_ni = 1'b0;
    {en_ni, dir_i, cap_ab_i, cap_ba_i, sel_ab_i, sel_ba_i} = {2'b00, 2'b11, 2'b11, 2'b00, 2'b11, 2'b11};
    a_i = 16'hffff; b_i = 16'h0f0f;
    #1;
    check("R10 b_o in reset", b_o, '0);
    check("R10 a_o in reset", a_o, '0);
    // R11: level held across reset release is not a rise
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    check("R11 no capture after reset", b_o, '0);
    @(negedge clk_i);
    cap_ab_i = 2'b00;
    @(negedge clk_i);
    cap_ab_i = 2'b11;
    @(posedge clk_i); #2;
    check("R4 capture after release", b_o, 16'hffff);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule